// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a synchronous serial control port. An external microcontroller uses it to write and read a bank of 8-bit control registers over three wires. The master always drives the serial clock. A single data line carries traffic in both directions. A level-sensitive framing input, also driven by the master, resets the slave's bit counter and marks the start of each transfer. No parity bit is used.

All three wires pass through a two-flop synchronizer before the block acts on them, so the block runs entirely on its own system clock. The slave samples the data line when it sees a rising serial clock edge, and it changes the bit it drives when it sees a falling edge.

Each transfer is sixteen bits, most significant bit first. The first byte is a direction flag followed by a 7-bit register address. The second byte is the data. Written bytes appear on a flat write-register output vector. Read bytes are taken from a flat read-register input vector, which the surrounding logic supplies.

Top module: `ser3_reg_slave`

## Requirements
- R1: After system reset every write register holds 0 and the data-line output enable is low.
- R2: A transfer whose first byte has bit 7 equal to 0 (write) and bits 6..0 equal to address A stores the following byte, sent MSB first, in write register A. Write register A occupies bits A*8+7..A*8 of `wr_regs_o`.
- R3: A transfer whose first byte has bit 7 equal to 1 (read) returns read register A on the data line, MSB first. Read register A is taken from bits A*8+7..A*8 of `rd_regs_i`. Each bit is presented after a falling serial edge and is valid at the next rising edge, and it is held steady between falling edges.
- R4: `sdat_oe` is high only during the data byte of a read. It is never high during the address byte or during any part of a write.
- R5: While `sframe_i` is high, `sdat_oe` is low in the same time step, with no clock delay.
- R6: A write that `sframe_i` cuts short, including a cut that arrives together with the eighth data bit's rising edge, leaves every write register unchanged.
- R7: A write to an address at or above the register count changes no register. A read of such an address returns 0x00.
- R8: Serial clock edges after the sixteenth bit of a transfer are ignored until `sframe_i` is asserted again.
- R9: Asserting `sframe_i` clears the bit counter, so a complete transfer that follows an aborted one decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| sdat_i | input | 1 | Level seen on the shared data line |
| sframe_i | input | 1 | Framing reset from the master, active high |
| sdat_o | output | 1 | Bit driven onto the data line |
| sdat_oe | output | 1 | Data-line driver enable |
| wr_regs_o | output | NUM_REGS*DATA_W | Write-register contents, register 0 in the low byte |
| rd_regs_i | input | NUM_REGS*DATA_W | Read-register contents, register 0 in the low byte |

## Verification
Two events can reach the synchronized domain in the same system cycle: a framing reset and the rising serial edge that carries the last data bit of a write. These are the commit and the abort. The bench provokes the collision by raising `sframe_i` and `sclk_i` together, so both pass the same synchronizer depth. It judges the outcome by the write-register outputs, which must be unchanged. The same principle is applied to a read: the framing reset is raised in the middle of the data byte, and the output enable is checked within the same time step.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } ser3_dir_e;

   function automatic int ser3_cnt_width(input int data_w);
      return $clog2(2 * data_w + 1);
   endfunction
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser3_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ser3_frame.sv
module ser3_frame #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_clr,
   input  logic              rise,
   input  logic              bit_i,
   output logic [CNT_W-1:0]  cnt,
   output logic              is_read,
   output logic              rd_load,
   output logic [DATA_W-2:0] rd_addr,
   output logic              wr_stb,
   output logic [DATA_W-2:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   import ser3_pkg::*;

   localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(2 * DATA_W - 1);
   localparam logic [CNT_W-1:0] DONE      = CNT_W'(2 * DATA_W);

   logic [DATA_W-2:0] sh;
   logic [DATA_W-2:0] addr_q;
   logic              take;

   assign take = rise && !frame_clr && (cnt != DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         sh      <= '0;
         addr_q  <= '0;
         is_read <= 1'b0;
      end else if (frame_clr) begin
         cnt     <= '0;
         is_read <= 1'b0;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         sh  <= {sh[DATA_W-3:0], bit_i};
         if (cnt == LAST_ADDR) begin
            addr_q  <= {sh[DATA_W-3:0], bit_i};
            is_read <= (ser3_dir_e'(sh[DATA_W-2]) == DIR_READ);
         end
      end
   end

   always_comb begin
      rd_load = take && (cnt == LAST_ADDR) && (ser3_dir_e'(sh[DATA_W-2]) == DIR_READ);
      rd_addr = {sh[DATA_W-3:0], bit_i};
      wr_stb  = take && (cnt == LAST_DATA) && !is_read;
      wr_addr = addr_q;
      wr_data = {sh, bit_i};
   end
endmodule

// File: rtl/ser3_regfile.sv
module ser3_regfile #(
   parameter int          DATA_W   = 8,
   parameter int          NUM_REGS = 8,
   parameter int          AW       = 7,
   parameter logic [7:0]  RST_VAL  = 8'h00
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_stb,
   input  logic [AW-1:0]                wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [AW-1:0]                rd_addr,
   input  logic [NUM_REGS*DATA_W-1:0]   rd_bank,
   output logic [DATA_W-1:0]            rd_data,
   output logic [NUM_REGS*DATA_W-1:0]   wr_bank
);
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [NUM_REGS-1:0][DATA_W-1:0] rbank;

   assign rbank   = rd_bank;
   assign wr_bank = regs;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 regs[i] <= DATA_W'(RST_VAL);
         else if (wr_stb && (wr_addr == AW'(i)))     regs[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == AW'(i)) rd_data = rbank[i];
      end
   end
endmodule

// File: rtl/ser3_tx.sv
module ser3_tx #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_clr,
   input  logic              fall,
   input  logic              is_read,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              rd_load,
   input  logic [DATA_W-1:0] rd_data,
   output logic              tx_bit,
   output logic              oe_q
);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] DONE  = CNT_W'(2 * DATA_W);

   logic [DATA_W-1:0] tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx   <= '0;
         oe_q <= 1'b0;
      end else if (frame_clr) begin
         oe_q <= 1'b0;
      end else begin
         if (rd_load) tx <= rd_data;
         if (fall && is_read) begin
            if (cnt == DONE)                 oe_q <= 1'b0;
            else if (cnt == FIRST && !oe_q)  oe_q <= 1'b1;
            else if (oe_q)                   tx   <= {tx[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign tx_bit = tx[DATA_W-1];
endmodule

// File: rtl/ser3_reg_slave.sv
module ser3_reg_slave #(
   parameter int         DATA_W      = 8,
   parameter int         NUM_REGS    = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RST_VAL     = 8'h00
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sclk_i,
   input  logic                       sdat_i,
   input  logic                       sframe_i,
   output logic                       sdat_o,
   output logic                       sdat_oe,
   output logic [NUM_REGS*DATA_W-1:0] wr_regs_o,
   input  logic [NUM_REGS*DATA_W-1:0] rd_regs_i
);
   localparam int AW    = DATA_W - 1;
   localparam int CNT_W = ser3_pkg::ser3_cnt_width(DATA_W);

   if (DATA_W < 4) begin : g_bad_width
      $error("ser3_reg_slave: DATA_W must be at least 4");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << AW)) begin : g_bad_regs
      $error("ser3_reg_slave: NUM_REGS out of address range");
   end

   logic [2:0]        sync_q;
   logic              sclk_s, sdat_s, frame_clr, sclk_d;
   logic              rise, fall;
   logic [CNT_W-1:0]  cnt;
   logic              is_read, rd_load, wr_stb, oe_q, tx_bit;
   logic [AW-1:0]     rd_addr, wr_addr;
   logic [DATA_W-1:0] wr_data, rd_data;

   ser3_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sframe_i, sdat_i, sclk_i}), .q(sync_q)
   );

   assign {frame_clr, sdat_s, sclk_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign rise = sclk_s && !sclk_d;
   assign fall = !sclk_s && sclk_d;

   ser3_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .rise(rise), .bit_i(sdat_s),
      .cnt(cnt), .is_read(is_read), .rd_load(rd_load), .rd_addr(rd_addr),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   ser3_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .AW(AW), .RST_VAL(RST_VAL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_bank(rd_regs_i), .rd_data(rd_data), .wr_bank(wr_regs_o)
   );

   ser3_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .fall(fall), .is_read(is_read),
      .cnt(cnt), .rd_load(rd_load), .rd_data(rd_data), .tx_bit(tx_bit), .oe_q(oe_q)
   );

   assign sdat_o  = tx_bit;
   assign sdat_oe = oe_q && !sframe_i;
endmodule

// File: rtl/ser3_reg_slave_chk.sv
module ser3_reg_slave_chk #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8,
   parameter int CNT_W    = 5
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       sframe_i,
   input logic                       sdat_o,
   input logic                       sdat_oe,
   input logic [NUM_REGS*DATA_W-1:0] wr_regs_o,
   input logic                       wr_stb,
   input logic [DATA_W-2:0]          wr_addr,
   input logic                       fall,
   input logic                       frame_clr,
   input logic                       is_read,
   input logic                       oe_q,
   input logic [CNT_W-1:0]           cnt
);
   localparam logic [DATA_W-1:0] NUM_L = DATA_W'(NUM_REGS);
   localparam logic [CNT_W-1:0]  DONE  = CNT_W'(2 * DATA_W);

   assert_line_free_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sframe_i |-> !sdat_oe);

   assert_drive_only_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sdat_oe |-> is_read);

   assert_drive_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && !fall && !frame_clr) |=> $stable(sdat_o));

   assert_commit_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(wr_regs_o));

   assert_out_of_range_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ({1'b0, wr_addr} >= NUM_L)) |=> $stable(wr_regs_o));

   assert_counter_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_clr |=> (cnt == '0));

   assert_counter_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DONE);
endmodule

bind ser3_reg_slave ser3_reg_slave_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sframe_i(sframe_i), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
   .wr_regs_o(wr_regs_o), .wr_stb(wr_stb), .wr_addr(wr_addr), .fall(fall),
   .frame_clr(frame_clr), .is_read(is_read), .oe_q(oe_q), .cnt(cnt)
);

// File: tb/ser3_reg_slave_bench.sv
module ser3_reg_slave_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int DW         = 8;
   localparam int NR         = 8;

   typedef struct {
      string      tag;
      logic [7:0] val;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, m_dat = 1'b0, sframe = 1'b0;
   logic sdat_o, sdat_oe, line;
   logic [NR*DW-1:0] wr_regs, rd_regs;

   int   checks = 0, errors = 0, cycles = 0;
   bit   done = 0;
   item_t exp_q[$], act_q[$];
   logic [7:0] model [NR];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign line = sdat_oe ? sdat_o : m_dat;

   ser3_reg_slave u_ser3_reg_slave (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(line), .sframe_i(sframe),
      .sdat_o(sdat_o), .sdat_oe(sdat_oe), .wr_regs_o(wr_regs), .rd_regs_i(rd_regs)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_regs(input string tag);
      for (int i = 0; i < NR; i++) check(tag, 64'(wr_regs[i*DW +: DW]), 64'(model[i]));
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame();
      sframe = 1'b1; wait_clk(4); sframe = 1'b0; wait_clk(4);
   endtask

   int oe_bad = 0;

   task automatic send_bit(input logic b);
      m_dat = b;
      wait_clk(HALF);
      if (sdat_oe) oe_bad++;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] d);
      frame();
      send_byte({1'b0, a});
      send_byte(d);
      wait_clk(HALF);
      if (a < NR) model[a] = d;
   endtask

   // driver pushes the expected read byte; the observed byte goes to the monitor
   task automatic do_read(input string tag, input logic [6:0] a, input logic [7:0] exp);
      logic [7:0] got;
      int oe_cnt;
      item_t e, o;
      e.tag = tag; e.val = exp; exp_q.push_back(e);
      frame();
      oe_bad = 0;
      send_byte({1'b1, a});
      check({tag, " R4 addr phase no drive"}, 64'(oe_bad), 64'd0);
      oe_cnt = 0;
      for (int i = 7; i >= 0; i--) begin
         wait_clk(HALF);
         got[i] = line;
         if (sdat_oe) oe_cnt++;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      check({tag, " R4 drive during data"}, 64'(oe_cnt), 64'd8);
      wait_clk(HALF);
      check({tag, " R4 released after data"}, 64'(sdat_oe), 64'd0);
      o.tag = tag; o.val = got; act_q.push_back(o);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         item_t e, o;
         wait (act_q.size() != 0);
         o = act_q.pop_front();
         e = exp_q.pop_front();
         check(e.tag, 64'(o.val), 64'(e.val));
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin
         rd_regs[i*DW +: DW] = 8'(i * 8'h1d) ^ 8'h5a;
         model[i] = 8'h00;
      end
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // R1 reset state
      check_regs("R1 reset regs");
      check("R1 reset oe", 64'(sdat_oe), 64'd0);

      // R2 writes with several patterns
      oe_bad = 0;
      do_write(7'd3, 8'ha5);
      do_write(7'd0, 8'h3c);
      do_write(7'd7, 8'hc3);
      check("R4 no drive during writes", 64'(oe_bad), 64'd0);
      check_regs("R2 write patterns");

      // R3 reads
      do_read("R3 read reg2", 7'd2, 8'(2 * 8'h1d) ^ 8'h5a);
      do_read("R3 read reg7", 7'd7, 8'(7 * 8'h1d) ^ 8'h5a);
      do_read("R3 read reg0", 7'd0, 8'h5a);

      // R7 out of range
      do_write(7'd20, 8'hff);
      check_regs("R7 out-of-range write");
      do_read("R7 out-of-range read", 7'd20, 8'h00);

      // R5 framing reset in the middle of a read
      frame();
      send_byte({1'b1, 7'd4});
      for (int i = 0; i < 3; i++) begin
         wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
      end
      wait_clk(2);
      check("R5 driving before abort", 64'(sdat_oe), 64'd1);
      sframe = 1'b1;
      #1;
      check("R5 immediate release", 64'(sdat_oe), 64'd0);
      wait_clk(4); sframe = 1'b0; wait_clk(4);

      // R6 truncated write after five data bits
      frame();
      send_byte({1'b0, 7'd3});
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      frame();
      check_regs("R6 truncated write");

      // R6 abort arriving with the eighth data bit
      frame();
      send_byte({1'b0, 7'd0});
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      m_dat = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1; sframe = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(2); sframe = 1'b0; wait_clk(4);
      check_regs("R6 abort on last bit");

      // R9 clean transfer after the abort
      do_write(7'd5, 8'h96);
      check_regs("R9 write after abort");

      // R8 extra bits after a complete write
      frame();
      send_byte({1'b0, 7'd1});
      send_byte(8'h42);
      model[1] = 8'h42;
      send_byte(8'h81); send_byte(8'hff); send_byte(8'h00);
      wait_clk(HALF);
      check_regs("R8 trailing bits ignored");
      do_read("R8 read after trailing", 7'd6, 8'(6 * 8'h1d) ^ 8'h5a);

      wait (act_q.size() == 0);
      wait_clk(4);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule